// File: doc/BRIEF.md
# Page Private/Shared Classifier

This controller decides, page by page, whether a page is used by one core only or by several. It holds a small page table. Each entry has a two-bit class, the id of the owning cache slice and a physical page number. Cores send translation-miss requests that carry a core id and a virtual page index. The controller answers each one with a single private/shared bit and the physical page number.

Classification is lazy: it is made only when a miss arrives. The first miss to an untouched page asks the allocator for a physical page over a request/acknowledge port. The page then becomes private to the requester. When a second core misses on a private page, the controller sends two requests to the old owner: a translation shootdown and an eviction of the page's blocks from its local slice. The page turns shared only after both are acknowledged, and only then does the reply go out. A shared page stays shared until reset.

The controller serves one request at a time and holds its request ready low while an allocation or a transition is open. An acknowledge that never comes leaves it waiting.

Top module: `page_class_ctrl`

## Requirements
- R1: A synchronous active-low reset marks every page untouched (class 2'b00), raises `req_ready` and drops every request and reply output. A page used before the reset is treated as untouched afterwards.
- R2: A miss to an untouched page raises `alloc_req` with `alloc_vpn` equal to the page index and holds both until `alloc_ack`. The reply is private (`rsp_shared`=0) and carries `alloc_ppn` as sampled with the acknowledge. The page becomes private (class 2'b01) with the requester as owner.
- R3: A miss from the owner of a private page is answered private, with the stored physical page, in the cycle after acceptance. It raises no allocation, shootdown or eviction request.
- R4: A miss from another core to a private page raises `shoot_req` with `shoot_core` equal to the owner and `shoot_vpn` equal to the page. It also raises `evict_req` with `evict_slice` equal to the owner and `evict_ppn` equal to the page's physical page. Each request stays high until its own acknowledge.
- R5: No reply is issued while either the shootdown or the eviction is unacknowledged, whichever order the acknowledges come in.
- R6: After both acknowledges, the page becomes shared (class 2'b10) and the reply is shared with the page's original physical page.
- R7: A miss of any core to a shared page, the former owner included, is answered shared in the cycle after acceptance with no handshake. No write ever moves a shared page to another class.
- R8: `req_ready` is low whenever an allocation, shootdown or eviction is open.
- R9: Each accepted request yields exactly one reply pulse, in acceptance order, and `rsp_core` names the requesting core.
- R10: Pages are independent: activity on one page index, including the lowest and highest, leaves other pages' class, owner and physical page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller can accept a request |
| req_core | input | CORE_W | Requesting core id |
| req_vpn | input | IDX_W | Virtual page index |
| rsp_valid | output | 1 | One-cycle reply pulse |
| rsp_core | output | CORE_W | Core the reply is for |
| rsp_shared | output | 1 | 1 = shared, 0 = private |
| rsp_ppn | output | PPN_W | Physical page number |
| alloc_req | output | 1 | Ask allocator for a physical page |
| alloc_vpn | output | IDX_W | Page being allocated |
| alloc_ack | input | 1 | Allocator done |
| alloc_ppn | input | PPN_W | Allocated physical page |
| shoot_req | output | 1 | Invalidate owner's translation |
| shoot_core | output | CORE_W | Core whose translation is invalidated |
| shoot_vpn | output | IDX_W | Page to invalidate |
| shoot_ack | input | 1 | Shootdown done |
| evict_req | output | 1 | Evict page from owner's slice |
| evict_slice | output | CORE_W | Slice to evict from |
| evict_ppn | output | PPN_W | Physical page to evict |
| evict_ack | input | 1 | Eviction done |

## Verification
The bench targets the private-to-shared transition with the two acknowledges in both orders and with long gaps between them. A controller that replied after only one acknowledge would send a shared reply while the eviction was still open. It follows up with repeat misses from the old owner, which a design that forgot the shared state would answer private. Back-to-back hits check the one-cycle reply and the ordering. A premature or missing reply, or a stray handshake on a hit, shows up as a queue miscompare. A mid-run reset followed by a miss to a previously shared page exposes a table that was not cleared. The bench also uses page indices 0 and 15, where a wrong index decode would corrupt a neighbouring entry.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
// Shared types for the page classifier: page class encoding and controller states.
package pcc_pkg;
    typedef enum logic [1:0] {
        PG_UNTOUCHED = 2'b00,
        PG_PRIVATE   = 2'b01,
        PG_SHARED    = 2'b10
    } pg_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ALLOC = 2'b01,
        ST_XFER  = 2'b10
    } ctl_state_e;
endpackage

// File: rtl/pcc_page_table.sv
`timescale 1ns/1ps
// Page table storage: one class/owner/ppn entry per page index.
// One combinational read port and one write port. Reset marks all pages untouched.
// Assumes NUM_PAGES is a power of two, so every index value addresses an entry.
module pcc_page_table
    import pcc_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int CORE_W    = 4,
    parameter int PPN_W     = 20,
    localparam int IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output pg_class_e         rd_class,
    output logic [CORE_W-1:0] rd_owner,
    output logic [PPN_W-1:0]  rd_ppn,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  pg_class_e         wr_class,
    input  logic [CORE_W-1:0] wr_owner,
    input  logic [PPN_W-1:0]  wr_ppn
);
    pg_class_e         cls_q   [NUM_PAGES];
    logic [CORE_W-1:0] owner_q [NUM_PAGES];
    logic [PPN_W-1:0]  ppn_q   [NUM_PAGES];

    genvar g;
    generate
        for (g = 0; g < NUM_PAGES; g++) begin : g_entry
            // Per-entry register: clear on reset, load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cls_q[g]   <= PG_UNTOUCHED;
                    owner_q[g] <= '0;
                    ppn_q[g]   <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    cls_q[g]   <= wr_class;
                    owner_q[g] <= wr_owner;
                    ppn_q[g]   <= wr_ppn;
                end
            end
        end
    endgenerate

    // Read port: select the addressed entry.
    always_comb begin
        rd_class = cls_q[rd_idx];
        rd_owner = owner_q[rd_idx];
        rd_ppn   = ppn_q[rd_idx];
    end

    // R7: the controller never demotes a shared page.
    p_shared_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cls_q[wr_idx] == PG_SHARED) |-> (wr_class == PG_SHARED));
endmodule

// File: rtl/pcc_ack_track.sv
`timescale 1ns/1ps
// Pending flag for one outgoing handshake: set on start, cleared by its acknowledge.
// Assumes start is not raised again while the flag is still pending.
module pcc_ack_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack,
    output logic pend
);
    // Track whether the request is still waiting for its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (start)      pend <= 1'b1;
        else if (pend && ack) pend <= 1'b0;
    end

    // R4: an outstanding request is held until acknowledged.
    p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);
endmodule

// File: rtl/page_class_ctrl.sv
`timescale 1ns/1ps
// Page private/shared classifier controller.
// Serves one translation-miss request at a time: it allocates untouched pages,
// answers owner and shared hits directly, and runs a shootdown plus eviction
// with the old owner before it promotes a private page to shared.
// Assumes the downstream agents eventually acknowledge; it waits otherwise.
module page_class_ctrl
    import pcc_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int NUM_CORES = 16,
    parameter int PPN_W     = 20,
    localparam int IDX_W    = $clog2(NUM_PAGES),
    localparam int CORE_W   = $clog2(NUM_CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic [IDX_W-1:0]  req_vpn,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic              rsp_shared,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              alloc_req,
    output logic [IDX_W-1:0]  alloc_vpn,
    input  logic              alloc_ack,
    input  logic [PPN_W-1:0]  alloc_ppn,
    output logic              shoot_req,
    output logic [CORE_W-1:0] shoot_core,
    output logic [IDX_W-1:0]  shoot_vpn,
    input  logic              shoot_ack,
    output logic              evict_req,
    output logic [CORE_W-1:0] evict_slice,
    output logic [PPN_W-1:0]  evict_ppn,
    input  logic              evict_ack
);
    localparam int N_ACK = 2;   // index 0: shootdown, index 1: eviction

    ctl_state_e        state_q, state_d;
    logic [CORE_W-1:0] cur_core_q;
    logic [IDX_W-1:0]  cur_vpn_q;
    logic [CORE_W-1:0] old_owner_q;
    logic [PPN_W-1:0]  old_ppn_q;

    logic              accept;
    logic [IDX_W-1:0]  rd_idx;
    pg_class_e         rd_class;
    logic [CORE_W-1:0] rd_owner;
    logic [PPN_W-1:0]  rd_ppn;
    logic              wr_en;
    pg_class_e         wr_class;
    logic [CORE_W-1:0] wr_owner;
    logic [PPN_W-1:0]  wr_ppn;

    logic              xfer_start;
    logic [N_ACK-1:0]  ack_vec;
    logic [N_ACK-1:0]  pend_vec;

    logic              rsp_set;
    logic              rsp_sh_d;
    logic [PPN_W-1:0]  rsp_ppn_d;
    logic [CORE_W-1:0] rsp_core_d;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_idx    = (state_q == ST_IDLE) ? req_vpn : cur_vpn_q;
    assign ack_vec   = {evict_ack, shoot_ack};

    pcc_page_table #(
        .NUM_PAGES (NUM_PAGES),
        .CORE_W    (CORE_W),
        .PPN_W     (PPN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_class (rd_class),
        .rd_owner (rd_owner),
        .rd_ppn   (rd_ppn),
        .wr_en    (wr_en),
        .wr_idx   (cur_vpn_q),
        .wr_class (wr_class),
        .wr_owner (wr_owner),
        .wr_ppn   (wr_ppn)
    );

    genvar a;
    generate
        for (a = 0; a < N_ACK; a++) begin : g_ack
            pcc_ack_track u_track (
                .clk   (clk),
                .rst_n (rst_n),
                .start (xfer_start),
                .ack   (ack_vec[a]),
                .pend  (pend_vec[a])
            );
        end
    endgenerate

    // Decide the next state, table write and reply for the current cycle.
    always_comb begin
        state_d    = state_q;
        wr_en      = 1'b0;
        wr_class   = rd_class;
        wr_owner   = rd_owner;
        wr_ppn     = rd_ppn;
        xfer_start = 1'b0;
        rsp_set    = 1'b0;
        rsp_sh_d   = 1'b0;
        rsp_ppn_d  = rd_ppn;
        rsp_core_d = cur_core_q;
        unique case (state_q)
            ST_IDLE: begin
                rsp_core_d = req_core;
                if (accept) begin
                    if (rd_class == PG_SHARED) begin
                        rsp_set  = 1'b1;
                        rsp_sh_d = 1'b1;
                    end else if (rd_class == PG_PRIVATE) begin
                        if (rd_owner == req_core) begin
                            rsp_set = 1'b1;
                        end else begin
                            xfer_start = 1'b1;
                            state_d    = ST_XFER;
                        end
                    end else begin
                        state_d = ST_ALLOC;
                    end
                end
            end
            ST_ALLOC: begin
                if (alloc_ack) begin
                    wr_en     = 1'b1;
                    wr_class  = PG_PRIVATE;
                    wr_owner  = cur_core_q;
                    wr_ppn    = alloc_ppn;
                    rsp_set   = 1'b1;
                    rsp_ppn_d = alloc_ppn;
                    state_d   = ST_IDLE;
                end
            end
            ST_XFER: begin
                if (pend_vec == '0) begin
                    wr_en    = 1'b1;
                    wr_class = PG_SHARED;
                    rsp_set  = 1'b1;
                    rsp_sh_d = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequence the controller and capture the request being served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_core_q  <= '0;
            cur_vpn_q   <= '0;
            old_owner_q <= '0;
            old_ppn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cur_core_q  <= req_core;
                cur_vpn_q   <= req_vpn;
                old_owner_q <= rd_owner;
                old_ppn_q   <= rd_ppn;
            end
        end
    end

    // Register the one-cycle reply pulse and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_core   <= '0;
            rsp_shared <= 1'b0;
            rsp_ppn    <= '0;
        end else begin
            rsp_valid <= rsp_set;
            if (rsp_set) begin
                rsp_core   <= rsp_core_d;
                rsp_shared <= rsp_sh_d;
                rsp_ppn    <= rsp_ppn_d;
            end
        end
    end

    assign alloc_req   = (state_q == ST_ALLOC);
    assign alloc_vpn   = cur_vpn_q;
    assign shoot_req   = pend_vec[0];
    assign shoot_core  = old_owner_q;
    assign shoot_vpn   = cur_vpn_q;
    assign evict_req   = pend_vec[1];
    assign evict_slice = old_owner_q;
    assign evict_ppn   = old_ppn_q;

    // R8: no new request is taken while a handshake is open.
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req || shoot_req || evict_req) |-> !req_ready);

    // R5: no reply while the shootdown or the eviction is outstanding.
    p_no_early_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shoot_req || evict_req) |-> !rsp_valid);

    // R2: an allocation request holds its page until acknowledged.
    p_alloc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_ack) |=> (alloc_req && $stable(alloc_vpn)));

    // R4: the shootdown targets a core other than the requester.
    p_shoot_other_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shoot_req |-> (shoot_core != cur_core_q));

    // R6: a completed transition is followed by a shared reply.
    p_xfer_reply_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER) && pend_vec == '0) |=> (rsp_valid && rsp_shared));
endmodule

// File: tb/page_class_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for the page classifier.
module page_class_ctrl_bench;
    localparam int NUM_PAGES = 16;
    localparam int NUM_CORES = 16;
    localparam int PPN_W     = 20;
    localparam int IDX_W     = 4;
    localparam int CORE_W    = 4;
    localparam int PPN_BASE  = 'h100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [CORE_W-1:0] req_core = '0;
    logic [IDX_W-1:0]  req_vpn = '0;
    logic              rsp_valid;
    logic [CORE_W-1:0] rsp_core;
    logic              rsp_shared;
    logic [PPN_W-1:0]  rsp_ppn;
    logic              alloc_req;
    logic [IDX_W-1:0]  alloc_vpn;
    logic              alloc_ack = 1'b0;
    logic [PPN_W-1:0]  alloc_ppn = '0;
    logic              shoot_req;
    logic [CORE_W-1:0] shoot_core;
    logic [IDX_W-1:0]  shoot_vpn;
    logic              shoot_ack = 1'b0;
    logic              evict_req;
    logic [CORE_W-1:0] evict_slice;
    logic [PPN_W-1:0]  evict_ppn;
    logic              evict_ack = 1'b0;

    page_class_ctrl #(
        .NUM_PAGES (NUM_PAGES),
        .NUM_CORES (NUM_CORES),
        .PPN_W     (PPN_W)
    ) u_page_class_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_core (req_core), .req_vpn (req_vpn),
        .rsp_valid (rsp_valid), .rsp_core (rsp_core),
        .rsp_shared (rsp_shared), .rsp_ppn (rsp_ppn),
        .alloc_req (alloc_req), .alloc_vpn (alloc_vpn),
        .alloc_ack (alloc_ack), .alloc_ppn (alloc_ppn),
        .shoot_req (shoot_req), .shoot_core (shoot_core),
        .shoot_vpn (shoot_vpn), .shoot_ack (shoot_ack),
        .evict_req (evict_req), .evict_slice (evict_slice),
        .evict_ppn (evict_ppn), .evict_ack (evict_ack)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int    core;
        bit    sh;
        int    ppn;
        bit    xfer;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    int m_cls   [NUM_PAGES];
    int m_owner [NUM_PAGES];
    int m_ppn   [NUM_PAGES];
    int pred_alloc = 0;
    int alloc_cnt  = 0;
    bit exp_alloc = 0;
    bit exp_xfer  = 0;
    int exp_vpn = 0;
    int exp_owner = 0;
    int exp_oppn = 0;
    bit shoot_done = 0;
    bit evict_done = 0;
    int alloc_dly = 1;
    int shoot_dly = 1;
    int evict_dly = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NUM_PAGES; i++) begin
            m_cls[i] = 0; m_owner[i] = 0; m_ppn[i] = 0;
        end
    endtask

    // Driver: predict the reply, push it, then present the request.
    task automatic send(input int core, input int vpn, input string tag);
        exp_t e;
        int   kind;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.core = core; e.xfer = 0; e.tag = tag;
        exp_vpn = vpn;
        if (m_cls[vpn] == 0) begin
            kind = 1;
            m_cls[vpn] = 1; m_owner[vpn] = core;
            m_ppn[vpn] = PPN_BASE + pred_alloc; pred_alloc++;
            e.sh = 0; e.ppn = m_ppn[vpn];
        end else if (m_cls[vpn] == 1 && m_owner[vpn] == core) begin
            kind = 0; e.sh = 0; e.ppn = m_ppn[vpn];
        end else if (m_cls[vpn] == 1) begin
            kind = 2;
            exp_owner = m_owner[vpn]; exp_oppn = m_ppn[vpn];
            shoot_done = 0; evict_done = 0;
            m_cls[vpn] = 2; e.sh = 1; e.ppn = m_ppn[vpn]; e.xfer = 1;
        end else begin
            kind = 0; e.sh = 1; e.ppn = m_ppn[vpn];
        end
        exp_alloc = (kind == 1);
        exp_xfer  = (kind == 2);
        exp_q.push_back(e);
        req_valid = 1'b1; req_core = CORE_W'(core); req_vpn = IDX_W'(vpn);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == 0) chk(rsp_valid == 1'b1, tag, "reply one cycle after accept", int'(rsp_valid), 1);
        else           chk(req_ready == 1'b0, "R8", "ready while busy", int'(req_ready), 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        exp_alloc = 0; exp_xfer = 0;
    endtask

    // Monitor: pop and compare each reply as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "reply with nothing pending", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(rsp_core) == e.core, "R9", "reply core", int'(rsp_core), e.core);
                chk(rsp_shared == e.sh, e.tag, "reply class", int'(rsp_shared), int'(e.sh));
                chk(int'(rsp_ppn) == e.ppn, e.tag, "reply ppn", int'(rsp_ppn), e.ppn);
                if (e.xfer)
                    chk(shoot_done && evict_done, "R5", "reply before both acks",
                        int'(shoot_done) + int'(evict_done), 2);
            end
        end
    end

    // Allocator responder.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && alloc_req) begin
                chk(exp_alloc, "R2", "unexpected allocation", 1, int'(exp_alloc));
                chk(int'(alloc_vpn) == exp_vpn, "R2", "alloc page", int'(alloc_vpn), exp_vpn);
                repeat (alloc_dly) @(negedge clk);
                alloc_ppn = PPN_W'(PPN_BASE + alloc_cnt);
                alloc_cnt++;
                alloc_ack = 1'b1;
                @(negedge clk);
                alloc_ack = 1'b0;
            end
        end
    end

    // Shootdown responder.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && shoot_req) begin
                chk(exp_xfer, "R4", "unexpected shootdown", 1, int'(exp_xfer));
                chk(int'(shoot_core) == exp_owner, "R4", "shoot core", int'(shoot_core), exp_owner);
                chk(int'(shoot_vpn) == exp_vpn, "R4", "shoot page", int'(shoot_vpn), exp_vpn);
                repeat (shoot_dly) @(negedge clk);
                shoot_ack = 1'b1; shoot_done = 1;
                @(negedge clk);
                shoot_ack = 1'b0;
            end
        end
    end

    // Eviction responder.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && evict_req) begin
                chk(exp_xfer, "R4", "unexpected eviction", 1, int'(exp_xfer));
                chk(int'(evict_slice) == exp_owner, "R4", "evict slice", int'(evict_slice), exp_owner);
                chk(int'(evict_ppn) == exp_oppn, "R4", "evict ppn", int'(evict_ppn), exp_oppn);
                repeat (evict_dly) @(negedge clk);
                evict_ack = 1'b1; evict_done = 1;
                @(negedge clk);
                evict_ack = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        // R1: idle outputs after reset
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "reply after reset", int'(rsp_valid), 0);
        chk(!alloc_req && !shoot_req && !evict_req, "R1", "handshake after reset",
            int'(alloc_req) + int'(shoot_req) + int'(evict_req), 0);

        alloc_dly = 2;
        send(3, 5, "R2");             // first touch
        send(3, 5, "R3");             // owner hit
        send(3, 5, "R3");             // back-to-back owner hit
        shoot_dly = 1; evict_dly = 4;
        send(7, 5, "R6");             // transition, shootdown acked first
        send(3, 5, "R7");             // former owner sees shared
        send(7, 5, "R7");
        send(11, 5, "R7");
        alloc_dly = 0;
        send(0, 9, "R2");
        shoot_dly = 6; evict_dly = 0;
        send(15, 9, "R6");            // transition, eviction acked first
        shoot_dly = 3; evict_dly = 3;
        send(2, 0, "R10");            // lowest index
        send(1, 15, "R10");           // highest index
        send(2, 0, "R10");            // neighbour untouched by page 15
        send(1, 15, "R10");
        send(4, 0, "R6");             // simultaneous acks
        send(1, 15, "R10");           // still private after page 0 went shared
        drain();

        do_reset();                   // mid-run reset
        chk(req_ready == 1'b1, "R1", "ready after second reset", int'(req_ready), 1);
        alloc_dly = 1;
        send(4, 5, "R1");             // formerly shared page reallocated as private
        send(4, 5, "R1");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule